// File: doc/BRIEF.md
# Serial ADC Frame Readout Controller

This block runs one full conversion-and-readout cycle of a multi-channel successive-approximation converter that has a frame-sync serial port. A trigger input, which may come from a bouncing switch, is first synchronized and filtered. A clean rising edge of the filtered trigger makes the controller pulse its convert-start output. The controller then follows the converter's busy flag through its rise and its fall. After the fall it opens a read frame by pulling frame sync low and drives exactly 32 serial clocks.

Every data line is sampled in the same frame. Each line carries two 16-bit slots. In each slot, four zero pad bits come before a 12-bit result. The controller returns two 12-bit results per line, one error flag per line for a nonzero pad bit, and a one-cycle done strobe. A busy flag that does not move within a programmable window ends the cycle with a timeout flag and no readout. The wait allows for the slow busy rise of a converter waking from auto-sleep.

Top module: `adc_frame_reader`

## Requirements
- R1: The trigger passes through a two-flop synchronizer and then a filter. A high level must hold for DEB_CYC (default 8) consecutive cycles before a cycle starts. A shorter high pulse starts nothing, and so does bounce shorter than that window.
- R2: A start raises `cnv_start_o` for exactly CONV_PULSE (default 3) cycles. Frame sync falls only after the synchronized busy flag has risen and then fallen again. `cnv_start_o` is never high while frame sync is low.
- R3: The controller accepts a busy rise that comes as late as BUSY_TIMEOUT−1 cycles after the wait begins (default 256). For example, a rise about 560 ns after convert-start still completes a normal frame.
- R4: A frame drives exactly 32 falling edges on `sclk_o` while `fsync_n_o` is low. `sclk_o` rests high, and it is high whenever `fsync_n_o` is high.
- R5: The first frame bit is captured while frame sync is low, before the first serial-clock fall. Each later bit is captured just before a fall. Frame bit 31 is first. Bits 27:16 give the first result and bits 11:0 give the second, so a frame of 0x03FF0400 reads 0x3FF and 0x400.
- R6: Each data line `sdo_i[l]` yields its own result pair in `res_a_o[12l+11:12l]` and `res_b_o[12l+11:12l]`. Lines do not affect each other.
- R7: `pad_err_o[l]` is 1 when any of frame bits 31:28 or 15:12 of line l is 1. The results are still reported.
- R8: If busy does not rise, or does not fall, within BUSY_TIMEOUT cycles, `timeout_o` is set and the controller returns to idle. In that case frame sync stays high and there is no done strobe. The flag clears at the next start.
- R9: `done_o` is high for one cycle, one cycle after `fsync_n_o` rises. Results and error flags change only with a done strobe.
- R10: A trigger that arrives while a cycle is running is ignored. It does not lead to a second conversion.
- R11: After reset, `cnv_start_o`, `done_o`, `timeout_o`, all results and all error flags are 0, and `fsync_n_o` and `sclk_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Raw asynchronous start trigger |
| busy_i | input | 1 | Converter busy flag (asynchronous) |
| sdo_i | input | LANES | Serial data lines, one per channel group |
| cnv_start_o | output | 1 | Convert-start pulse |
| fsync_n_o | output | 1 | Frame sync, active low |
| sclk_o | output | 1 | Serial clock, rests high |
| res_a_o | output | LANES*12 | First-slot result for each line |
| res_b_o | output | LANES*12 | Second-slot result for each line |
| pad_err_o | output | LANES | Nonzero pad bit seen on the line |
| done_o | output | 1 | One-cycle frame-complete strobe |
| timeout_o | output | 1 | Busy wait expired |

## Verification
The bench drives the data lines the way the converter does. The most significant bit appears at the frame-sync fall, and the line shifts on every serial-clock fall. The bench therefore computes each expected result from the frame word alone. The convert-start width is counted in clock cycles, and the done strobe must come exactly one cycle after frame sync rises. All outputs are read on the falling clock edge, one cycle after the monitor records the strobe, while the results are held stable. Trigger tests include deliberate gaps: a short pulse, bounce, a retrigger during a cycle, and busy stuck low or stuck high. Each gap is long enough to cover the synchronizer, the filter and the busy timeout before the outputs are checked.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned RES_BITS   = 12;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CONV    = 3'd1,
    ST_WAIT_HI = 3'd2,
    ST_WAIT_LO = 3'd3,
    ST_SETUP   = 3'd4,
    ST_SHIFT   = 3'd5,
    ST_FINISH  = 3'd6
  } rd_state_t;
endpackage

// File: rtl/adcrd_sync2.sv
module adcrd_sync2 #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/adcrd_debounce.sv
module adcrd_debounce #(
  parameter int unsigned DEB_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic rise_o
);
  localparam int unsigned CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic          lvl;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl    <= 1'b0;
      cnt    <= '0;
      rise_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      if (din_i == lvl) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        lvl    <= din_i;
        cnt    <= '0;
        rise_o <= din_i;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // checker: length of the current run of high input samples
  logic [CW:0] run_hi;
  always_ff @(posedge clk) begin
    if (rst) run_hi <= '0;
    else if (!din_i) run_hi <= '0;
    else if (run_hi < (CW+1)'(DEB_CYC)) run_hi <= run_hi + 1'b1;
  end

  assert_start_filtered_R1: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> (run_hi >= (CW+1)'(DEB_CYC)));
endmodule

// File: rtl/adcrd_seq.sv
module adcrd_seq
  import adcrd_pkg::*;
#(
  parameter int unsigned CONV_PULSE   = 3,
  parameter int unsigned SETUP_CYC    = 2,
  parameter int unsigned HALF_CYC     = 2,
  parameter int unsigned BUSY_TIMEOUT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic busy_i,
  output logic cnv_start_o,
  output logic fsync_n_o,
  output logic sclk_o,
  output logic cap_o,
  output logic load_o,
  output logic done_o,
  output logic timeout_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_TIMEOUT + CONV_PULSE + SETUP_CYC + HALF_CYC + 1);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_PULSE - 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(BUSY_TIMEOUT - 1);
  localparam logic [BIT_W-1:0] NFALL_END  = BIT_W'(FRAME_BITS);

  rd_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] nfall;

  always_comb begin
    cap_o  = ((state == ST_SETUP) && (cnt == SETUP_LAST)) ||
             ((state == ST_SHIFT) && sclk_o && (cnt == HALF_LAST) && (nfall != NFALL_END));
    load_o = (state == ST_FINISH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      nfall       <= '0;
      cnv_start_o <= 1'b0;
      fsync_n_o   <= 1'b1;
      sclk_o      <= 1'b1;
      done_o      <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start_i) begin
            state       <= ST_CONV;
            cnv_start_o <= 1'b1;
            timeout_o   <= 1'b0;
          end
        end
        ST_CONV: begin
          if (cnt == CONV_LAST) begin
            cnv_start_o <= 1'b0;
            cnt         <= '0;
            state       <= ST_WAIT_HI;
          end else cnt <= cnt + 1'b1;
        end
        ST_WAIT_HI: begin
          if (busy_i) begin
            cnt   <= '0;
            state <= ST_WAIT_LO;
          end else if (cnt == WAIT_LAST) begin
            timeout_o <= 1'b1;
            cnt       <= '0;
            state     <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_WAIT_LO: begin
          if (!busy_i) begin
            cnt       <= '0;
            fsync_n_o <= 1'b0;
            state     <= ST_SETUP;
          end else if (cnt == WAIT_LAST) begin
            timeout_o <= 1'b1;
            cnt       <= '0;
            state     <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_SETUP: begin
          if (cnt == SETUP_LAST) begin
            cnt    <= '0;
            sclk_o <= 1'b0;
            nfall  <= BIT_W'(1);
            state  <= ST_SHIFT;
          end else cnt <= cnt + 1'b1;
        end
        ST_SHIFT: begin
          if (cnt == HALF_LAST) begin
            cnt <= '0;
            if (!sclk_o) begin
              sclk_o <= 1'b1;
              if (nfall == NFALL_END) begin
                fsync_n_o <= 1'b1;
                state     <= ST_FINISH;
              end
            end else begin
              sclk_o <= 1'b0;
              nfall  <= nfall + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_FINISH: begin
          done_o <= 1'b1;
          nfall  <= '0;
          state  <= ST_IDLE;
        end
        default: begin
          state       <= ST_IDLE;
          cnt         <= '0;
          nfall       <= '0;
          cnv_start_o <= 1'b0;
          fsync_n_o   <= 1'b1;
          sclk_o      <= 1'b1;
        end
      endcase
    end
  end

  // checker: serial-clock falls seen during the current frame
  logic             sclk_q;
  logic [BIT_W-1:0] chk_falls;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b1;
      chk_falls <= '0;
    end else begin
      sclk_q <= sclk_o;
      if (fsync_n_o) chk_falls <= '0;
      else if (sclk_q && !sclk_o) chk_falls <= chk_falls + 1'b1;
    end
  end

  assert_sclk_rests_high_R4: assert property (@(posedge clk) disable iff (rst)
    fsync_n_o |-> sclk_o);
  assert_frame_32_clocks_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_n_o) |-> (chk_falls == NFALL_END));
  assert_read_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(fsync_n_o) |-> !$past(busy_i));
  assert_conv_outside_frame_R2: assert property (@(posedge clk) disable iff (rst)
    cnv_start_o |-> fsync_n_o);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_timeout_no_frame_R8: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (fsync_n_o && !done_o));
endmodule

// File: rtl/adcrd_lane.sv
module adcrd_lane
  import adcrd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sdo_i,
  input  logic                cap_i,
  input  logic                load_i,
  output logic [RES_BITS-1:0] res_a_o,
  output logic [RES_BITS-1:0] res_b_o,
  output logic                pad_err_o
);
  localparam int unsigned SLOT = FRAME_BITS / 2;
  localparam int unsigned PAD  = SLOT - RES_BITS;

  logic [FRAME_BITS-1:0] sh;
  logic                  pad_bad;

  assign pad_bad = (|sh[FRAME_BITS-1 -: PAD]) | (|sh[SLOT-1 -: PAD]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      res_a_o   <= '0;
      res_b_o   <= '0;
      pad_err_o <= 1'b0;
    end else begin
      if (cap_i) sh <= {sh[FRAME_BITS-2:0], sdo_i};
      if (load_i) begin
        res_a_o   <= sh[SLOT +: RES_BITS];
        res_b_o   <= sh[0 +: RES_BITS];
        pad_err_o <= pad_bad;
      end
    end
  end

  // checker: bits captured since the last load
  logic [$clog2(FRAME_BITS+1)-1:0] caps;
  always_ff @(posedge clk) begin
    if (rst) caps <= '0;
    else if (load_i) caps <= '0;
    else if (cap_i) caps <= caps + 1'b1;
  end

  assert_full_frame_captured_R5: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (caps == ($clog2(FRAME_BITS+1))'(FRAME_BITS)));
  assert_results_held_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(load_i) |-> $stable(res_a_o));
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adcrd_pkg::*;
#(
  parameter int unsigned LANES        = 4,
  parameter int unsigned DEB_CYC      = 8,
  parameter int unsigned CONV_PULSE   = 3,
  parameter int unsigned SETUP_CYC    = 2,
  parameter int unsigned HALF_CYC     = 2,
  parameter int unsigned BUSY_TIMEOUT = 256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig_i,
  input  logic                      busy_i,
  input  logic [LANES-1:0]          sdo_i,
  output logic                      cnv_start_o,
  output logic                      fsync_n_o,
  output logic                      sclk_o,
  output logic [LANES*RES_BITS-1:0] res_a_o,
  output logic [LANES*RES_BITS-1:0] res_b_o,
  output logic [LANES-1:0]          pad_err_o,
  output logic                      done_o,
  output logic                      timeout_o
);
  logic [1:0] raw_in, sync_out;
  logic       trig_s, busy_s, start, cap, load;

  assign raw_in = {busy_i, trig_i};
  assign trig_s = sync_out[0];
  assign busy_s = sync_out[1];

  adcrd_sync2 #(.WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(sync_out)
  );

  adcrd_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk(clk), .rst(rst), .din_i(trig_s), .rise_o(start)
  );

  adcrd_seq #(
    .CONV_PULSE(CONV_PULSE), .SETUP_CYC(SETUP_CYC),
    .HALF_CYC(HALF_CYC), .BUSY_TIMEOUT(BUSY_TIMEOUT)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start), .busy_i(busy_s),
    .cnv_start_o(cnv_start_o), .fsync_n_o(fsync_n_o), .sclk_o(sclk_o),
    .cap_o(cap), .load_o(load), .done_o(done_o), .timeout_o(timeout_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    adcrd_lane u_lane (
      .clk(clk), .rst(rst), .sdo_i(sdo_i[l]), .cap_i(cap), .load_i(load),
      .res_a_o(res_a_o[l*RES_BITS +: RES_BITS]),
      .res_b_o(res_b_o[l*RES_BITS +: RES_BITS]),
      .pad_err_o(pad_err_o[l])
    );
  end
endmodule

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_i = 1'b0;
  logic busy_i = 1'b0;
  logic [NL-1:0] sdo_i = '0;
  logic cnv_start_o, fsync_n_o, sclk_o, done_o, timeout_o;
  logic [NL*12-1:0] res_a_o, res_b_o;
  logic [NL-1:0] pad_err_o;

  always #4 clk = ~clk;

  adc_frame_reader u0 (
    .clk(clk), .rst(rst), .trig_i(trig_i), .busy_i(busy_i), .sdo_i(sdo_i),
    .cnv_start_o(cnv_start_o), .fsync_n_o(fsync_n_o), .sclk_o(sclk_o),
    .res_a_o(res_a_o), .res_b_o(res_b_o), .pad_err_o(pad_err_o),
    .done_o(done_o), .timeout_o(timeout_o)
  );

  // stimulus table: line words 0..3, busy rise delay, busy length (cycles)
  localparam logic [159:0] VEC [6] = '{
    {32'h03FF0400, 32'h03FF0400, 32'h03FF0400, 32'h03FF0400, 16'd2,  16'd20},
    {32'h0FFF0000, 32'h00000FFF, 32'h0AAA0555, 32'h01230ABC, 16'd3,  16'd30},
    {32'h040003FF, 32'h00010800, 32'h08000001, 32'h0FFE0003, 16'd70, 16'd25},
    {32'h83FF0400, 32'h00001000, 32'h0F0F0F0F, 32'h0000F000, 16'd3,  16'd15},
    {32'h00000001, 32'h00000001, 32'h00000001, 32'h00000001, 16'd2,  16'd10},
    {32'h08000000, 32'h08000000, 32'h00000800, 32'h00000800, 16'd2,  16'd10}
  };

  int checks = 0, fails = 0;
  logic [31:0] word [NL];
  int busy_dly = 2, busy_len = 20;
  bit busy_nohi = 0, busy_nolo = 0;

  // converter model: busy response
  always @(posedge cnv_start_o) begin
    if (!busy_nohi) begin
      repeat (busy_dly) @(posedge clk);
      busy_i <= 1'b1;
      if (!busy_nolo) begin
        repeat (busy_len) @(posedge clk);
        busy_i <= 1'b0;
      end
    end
  end

  // converter model: serial data, MSB at frame-sync fall, shift on clock fall
  int bidx = 31;
  always @(negedge fsync_n_o) begin
    bidx = 31;
    #1;
    for (int l = 0; l < NL; l++) sdo_i[l] = word[l][31];
  end
  always @(negedge sclk_o) begin
    if (!fsync_n_o) begin
      bidx = bidx - 1;
      #1;
      for (int l = 0; l < NL; l++) sdo_i[l] = (bidx >= 0) ? word[l][bidx[4:0]] : 1'b0;
    end
  end

  // monitors
  int nfall = 0, frames = 0, conv_rises = 0, done_cnt = 0;
  int cw_run = 0, cw_last = 0, since_fs = 99, done_gap = -1, cycles = 0;
  bit fs_busy_bad = 0;
  logic fs_prev = 1'b1;
  always @(negedge fsync_n_o) begin
    nfall = 0; frames++;
    if (busy_i) fs_busy_bad = 1;
  end
  always @(negedge sclk_o) if (!fsync_n_o) nfall++;
  always @(posedge cnv_start_o) conv_rises++;
  always @(negedge clk) begin
    cycles++;
    if (cnv_start_o) cw_run++;
    else if (cw_run > 0) begin cw_last = cw_run; cw_run = 0; end
    if (!fs_prev && fsync_n_o) since_fs = 0; else since_fs++;
    fs_prev = fsync_n_o;
    if (done_o) begin done_cnt++; done_gap = since_fs; end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic press(input int hi);
    trig_i = 1'b1;
    repeat (hi) @(negedge clk);
    trig_i = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic wait_done(input int lim, output bit got);
    int d0;
    d0 = done_cnt; got = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (done_cnt != d0) begin got = 1; break; end
    end
    @(negedge clk);
  endtask

  task automatic check_results(input string tag);
    for (int l = 0; l < NL; l++) begin
      check(res_a_o[l*12 +: 12] == word[l][27:16], {tag, " R5 first result"}, 32'(res_a_o[l*12 +: 12]), 32'(word[l][27:16]));
      check(res_b_o[l*12 +: 12] == word[l][11:0], {tag, " R6 second result"}, 32'(res_b_o[l*12 +: 12]), 32'(word[l][11:0]));
      check(pad_err_o[l] == ((|word[l][31:28]) | (|word[l][15:12])), {tag, " R7 pad flag"},
            32'(pad_err_o[l]), 32'((|word[l][31:28]) | (|word[l][15:12])));
    end
  endtask

  initial begin
    bit got;
    int c0, f0;
    logic [NL*12-1:0] held_a;

    repeat (5) @(negedge clk);
    // R11 reset state
    check(cnv_start_o == 0 && done_o == 0 && timeout_o == 0, "R11 controls low", {29'b0, cnv_start_o, done_o, timeout_o}, 0);
    check(fsync_n_o == 1 && sclk_o == 1, "R11 frame idle", {30'b0, fsync_n_o, sclk_o}, 3);
    check(res_a_o == 0 && res_b_o == 0 && pad_err_o == 0, "R11 results zero", 32'(res_a_o[31:0]), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 short pulse ignored
    press(4);
    repeat (40) @(negedge clk);
    check(conv_rises == 0, "R1 short pulse", conv_rises, 0);

    // R1 bounce then stable level gives exactly one conversion
    for (int k = 0; k < NL; k++) word[k] = VEC[0][159-32*k -: 32];
    for (int k = 0; k < 6; k++) begin
      trig_i = 1'b1; repeat (2) @(negedge clk);
      trig_i = 1'b0; repeat (2) @(negedge clk);
    end
    fork press(20); wait_done(3000, got); join
    repeat (60) @(negedge clk);
    check(got && conv_rises == 1, "R1 bounce", conv_rises, 1);

    // table walk
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < NL; k++) word[k] = VEC[i][159-32*k -: 32];
      busy_dly = int'(VEC[i][31:16]);
      busy_len = int'(VEC[i][15:0]);
      fs_busy_bad = 0;
      fork press(20); wait_done(3000, got); join
      check(got, (busy_dly > 50) ? "R3 slow busy rise completes" : "R9 done seen", got, 1);
      check_results($sformatf("vec%0d", i));
      check(nfall == 32, "R4 clock count", nfall, 32);
      check(cw_last == 3, "R2 convert pulse width", cw_last, 3);
      check(!fs_busy_bad, "R2 frame after busy fall", fs_busy_bad, 0);
      check(done_gap == 1, "R9 done timing", done_gap, 1);
    end

    // R9 results held without a new frame
    held_a = res_a_o;
    repeat (80) @(negedge clk);
    check(res_a_o == held_a && done_o == 0, "R9 hold", 32'(res_a_o[31:0]), 32'(held_a[31:0]));

    // R10 retrigger during a running cycle is ignored
    for (int k = 0; k < NL; k++) word[k] = VEC[1][159-32*k -: 32];
    busy_dly = 2; busy_len = 60;
    c0 = conv_rises;
    fork
      begin press(20); press(20); end
      wait_done(3000, got);
    join
    repeat (150) @(negedge clk);
    check(got && conv_rises == c0 + 1, "R10 retrigger", conv_rises - c0, 1);
    check_results("R10");

    // R8 busy never rises
    busy_nohi = 1; f0 = frames; c0 = done_cnt;
    press(20);
    repeat (300) @(negedge clk);
    check(timeout_o == 1, "R8 no busy rise flag", timeout_o, 1);
    check(frames == f0 && done_cnt == c0, "R8 no frame on timeout", frames - f0, 0);
    busy_nohi = 0;

    // R8 busy never falls
    busy_nolo = 1; busy_dly = 2;
    press(20);
    repeat (300) @(negedge clk);
    check(timeout_o == 1 && frames == f0 && done_cnt == c0, "R8 stuck busy", timeout_o, 1);
    busy_nolo = 0; busy_i = 1'b0;
    repeat (10) @(negedge clk);

    // R8 flag clears on next start
    for (int k = 0; k < NL; k++) word[k] = VEC[0][159-32*k -: 32];
    busy_len = 20;
    fork press(20); wait_done(3000, got); join
    check(got && timeout_o == 0, "R8 flag cleared", timeout_o, 0);
    check_results("R8 recovery");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule